// File: doc/BRIEF.md
# Drift-Compensated Time-of-Day Counter

This block holds the running time of a precision time protocol clock. A 125 MHz oscillator clocks it, and on every cycle it adds a nominal 8 ns to a nanosecond register. The nanosecond register rolls over at one second. A narrow seconds field counts those rollovers and wraps modulo 8, so a wider seconds count has to be kept by whatever reads the block.

A fractional frequency trim comes from a phase accumulator. While trimming is enabled, the 30-bit addend is added to the accumulator once per cycle. Each carry out of the accumulator changes that cycle's increment by one nanosecond: 9 ns when the sign input is clear, 7 ns when it is set. The average rate of carries, and so the trim, equals addend / 2^30 per cycle. The addend is limited to 2^29, so the frequency can move by at most 6.25%.

A load strobe places a new seconds value and nanosecond value into the counter. It takes precedence over stepping in the same cycle.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is high, and on the first clock edge after it, the nanosecond output and the seconds output are 0 and the trim accumulator is cleared. The first step after reset therefore carries no extra nanosecond until the accumulated addend reaches 2^30.
- R2: When the trim enable is low and no load is pending, every clock edge adds exactly 8 to the nanosecond output, whatever the addend and sign inputs are.
- R3: When the trim enable is high, the addend is added to a 30-bit accumulator on each edge. Counting from a load, the number of extra or missing nanoseconds after N stepping edges is floor(N·A/2^30), where A is the effective addend.
- R4: On an edge where the accumulator carries out, the step is 9 ns if the sign input is 0 and 7 ns if it is 1. On edges without a carry the step stays 8 ns.
- R5: An addend above 2^29 is treated as exactly 2^29, which gives one carry every second edge.
- R6: When the stepped nanosecond value would reach or pass 1,000,000,000, 10^9 is subtracted from it and the 3-bit seconds output increments modulo 8. On every other step the seconds output holds.
- R7: A load strobe sampled high on an edge writes the load seconds and load nanoseconds directly to the outputs, suppresses that edge's step, and clears the trim accumulator.
- R8: While the trim enable is low, the accumulator keeps its phase. When trimming is enabled again, carries resume from the phase it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| drift_en | input | 1 | Enables the fractional trim |
| drift_neg | input | 1 | Trim sign: 0 gives a 9 ns step on carry, 1 gives a 7 ns step |
| drift_addend | input | 30 | Accumulator addend, limited to 2^29 |
| load_stb | input | 1 | Loads the time on this edge |
| load_sec | input | 3 | Seconds value to load |
| load_ns | input | 30 | Nanosecond value to load (below 10^9) |
| tod_ns | output | 30 | Current nanoseconds of the second, registered |
| tod_sec | output | 3 | Seconds count modulo 8, registered |

## Verification
The bound checker looks at every edge. It confirms that a load lands exactly, that an untrimmed step is 8 ns, and that a trimmed step stays within 8..9 for a positive sign and 7..8 for a negative sign. It also confirms that the nanosecond value stays below one second and that the seconds field moves only on a rollover, by exactly one. Carry counts over long runs, addend clamping, the accumulator clear on load and after reset, and phase retention across a disabled interval all depend on history. Only the bench's directed scenarios show these, by comparing the nanosecond output against floor(N·A/2^30).

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  // Per-cycle trim decision passed from the accumulator to the counter
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_UP   = 2'd1,
    TRIM_DOWN = 2'd2
  } trim_e;

  localparam int unsigned NS_PER_SECOND = 1_000_000_000;
endpackage

// File: rtl/ptp_drift_accum.sv
module ptp_drift_accum
  import ptp_tod_pkg::*;
#(
  parameter int ACC_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             neg,
  input  logic [ACC_W-1:0] addend,
  output trim_e            trim
);
  localparam logic [ACC_W-1:0] ADD_MAX = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend_eff;
  logic [ACC_W:0]   sum;

  // Limit the carry rate to one every second cycle
  always_comb begin
    addend_eff = (addend > ADD_MAX) ? ADD_MAX : addend;
    sum        = {1'b0, acc_q} + {1'b0, addend_eff};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= sum[ACC_W-1:0];
    end
  end

  always_comb begin
    trim = TRIM_NONE;
    if (en && !clr && sum[ACC_W]) begin
      trim = neg ? TRIM_DOWN : TRIM_UP;
    end
  end
endmodule

// File: rtl/ptp_ns_counter.sv
module ptp_ns_counter
  import ptp_tod_pkg::*;
#(
  parameter int          NS_W     = 30,
  parameter int          SEC_W    = 3,
  parameter int unsigned NOM_STEP = 8,
  parameter int unsigned ROLL_NS  = NS_PER_SECOND
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [NS_W-1:0]  load_ns,
  input  trim_e            trim,
  output logic [NS_W-1:0]  ns_q,
  output logic [SEC_W-1:0] sec_q
);
  localparam logic [NS_W:0] STEP_NOM  = (NS_W+1)'(NOM_STEP);
  localparam logic [NS_W:0] STEP_UP   = (NS_W+1)'(NOM_STEP + 1);
  localparam logic [NS_W:0] STEP_DOWN = (NS_W+1)'(NOM_STEP - 1);
  localparam logic [NS_W:0] ROLL      = (NS_W+1)'(ROLL_NS);

  logic [NS_W:0]   step;
  logic [NS_W:0]   raw;
  logic            wrap;
  logic [NS_W-1:0] ns_next;

  always_comb begin
    unique case (trim)
      TRIM_UP:   step = STEP_UP;
      TRIM_DOWN: step = STEP_DOWN;
      default:   step = STEP_NOM;
    endcase
    raw     = {1'b0, ns_q} + step;
    wrap    = (raw >= ROLL);
    ns_next = wrap ? NS_W'(raw - ROLL) : raw[NS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (load) begin
      ns_q  <= load_ns;
      sec_q <= load_sec;
    end else begin
      ns_q <= ns_next;
      if (wrap) begin
        sec_q <= sec_q + SEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int          NS_W     = 30,
  parameter int          SEC_W    = 3,
  parameter int          ACC_W    = 30,
  parameter int unsigned NOM_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drift_en,
  input  logic             drift_neg,
  input  logic [ACC_W-1:0] drift_addend,
  input  logic             load_stb,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [NS_W-1:0]  load_ns,
  output logic [NS_W-1:0]  tod_ns,
  output logic [SEC_W-1:0] tod_sec
);
  trim_e trim;

  ptp_drift_accum #(
    .ACC_W (ACC_W)
  ) accum_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (load_stb),
    .en     (drift_en),
    .neg    (drift_neg),
    .addend (drift_addend),
    .trim   (trim)
  );

  ptp_ns_counter #(
    .NS_W     (NS_W),
    .SEC_W    (SEC_W),
    .NOM_STEP (NOM_STEP),
    .ROLL_NS  (NS_PER_SECOND)
  ) count_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load_stb),
    .load_sec (load_sec),
    .load_ns  (load_ns),
    .trim     (trim),
    .ns_q     (tod_ns),
    .sec_q    (tod_sec)
  );
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk #(
  parameter int          NS_W     = 30,
  parameter int          SEC_W    = 3,
  parameter int          ACC_W    = 30,
  parameter int unsigned NOM_STEP = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             drift_en,
  input logic             drift_neg,
  input logic [ACC_W-1:0] drift_addend,
  input logic             load_stb,
  input logic [SEC_W-1:0] load_sec,
  input logic [NS_W-1:0]  load_ns,
  input logic [NS_W-1:0]  tod_ns,
  input logic [SEC_W-1:0] tod_sec
);
  localparam logic [NS_W-1:0] ROLL = NS_W'(ptp_tod_pkg::NS_PER_SECOND);
  localparam logic [NS_W-1:0] NOM  = NS_W'(NOM_STEP);

  // R7: a load lands exactly on the next edge
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_stb)) |->
      (tod_ns == $past(load_ns) && tod_sec == $past(load_sec)));

  // R2: untrimmed steps are nominal
  p_nominal_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb) && !$past(drift_en) && tod_ns >= $past(tod_ns)) |->
      (tod_ns - $past(tod_ns) == NOM));

  // R4: positive trim only lengthens a step by one
  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb) && $past(drift_en) && !$past(drift_neg) &&
     tod_ns >= $past(tod_ns)) |->
      (tod_ns - $past(tod_ns) == NOM || tod_ns - $past(tod_ns) == NOM + NS_W'(1)));

  // R4: negative trim only shortens a step by one
  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb) && $past(drift_en) && $past(drift_neg) &&
     tod_ns >= $past(tod_ns)) |->
      (tod_ns - $past(tod_ns) == NOM || tod_ns - $past(tod_ns) == NOM - NS_W'(1)));

  // R6: nanoseconds stay inside one second after stepping
  p_range_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb)) |-> (tod_ns < ROLL));

  // R6: rollover advances seconds by one
  p_wrap_sec_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb) && tod_ns < $past(tod_ns)) |->
      (tod_sec == $past(tod_sec) + SEC_W'(1)));

  // R6: seconds hold when there is no rollover
  p_sec_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_stb) && tod_ns >= $past(tod_ns)) |->
      $stable(tod_sec));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(
  .NS_W     (NS_W),
  .SEC_W    (SEC_W),
  .ACC_W    (ACC_W),
  .NOM_STEP (NOM_STEP)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .drift_en     (drift_en),
  .drift_neg    (drift_neg),
  .drift_addend (drift_addend),
  .load_stb     (load_stb),
  .load_sec     (load_sec),
  .load_ns      (load_ns),
  .tod_ns       (tod_ns),
  .tod_sec      (tod_sec)
);

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        drift_en = 1'b0;
  logic        drift_neg = 1'b0;
  logic [29:0] drift_addend = '0;
  logic        load_stb = 1'b0;
  logic [2:0]  load_sec = '0;
  logic [29:0] load_ns = '0;
  logic [29:0] tod_ns;
  logic [2:0]  tod_sec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk          (clk),
    .rst          (rst),
    .drift_en     (drift_en),
    .drift_neg    (drift_neg),
    .drift_addend (drift_addend),
    .load_stb     (load_stb),
    .load_sec     (load_sec),
    .load_ns      (load_ns),
    .tod_ns       (tod_ns),
    .tod_sec      (tod_sec)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; load takes effect on the next posedge
  task automatic do_load(input logic [2:0] s, input logic [29:0] n);
    load_sec = s;
    load_ns  = n;
    load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint carries(input longint n, input longint a);
    longint ae;
    ae = (a > 64'd536870912) ? 64'd536870912 : a;
    return (n * ae) >> 30;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 ns in reset", tod_ns, 0);
    check("R1 sec in reset", tod_sec, 0);
    drift_en = 1'b1; drift_neg = 1'b0; drift_addend = 30'h2000_0000;
    rst = 1'b0;
    run(1);
    check("R1 first step no carry", tod_ns, 8);
    run(1);
    check("R1 second step carries", tod_ns, 17);
    drift_en = 1'b0;
  endtask

  task automatic t_nominal();
    drift_en = 1'b0; drift_addend = 30'h3FFF_FFFF; drift_neg = 1'b1;
    do_load(3'd2, 30'd1000);
    check("R7 load ns", tod_ns, 1000);
    check("R7 load sec", tod_sec, 2);
    run(100);
    check("R2 nominal ns", tod_ns, 1000 + 800);
    check("R2 nominal sec", tod_sec, 2);
  endtask

  task automatic t_drift(input logic neg, input logic [29:0] a, input int n);
    longint c;
    drift_en = 1'b1; drift_neg = neg; drift_addend = a;
    do_load(3'd1, 30'd5000);
    run(n);
    c = carries(n, a);
    if (neg) check("R3 R4 negative trim", tod_ns, 5000 + 8 * n - c);
    else     check("R3 R4 positive trim", tod_ns, 5000 + 8 * n + c);
    drift_en = 1'b0;
  endtask

  task automatic t_clamp();
    drift_en = 1'b1; drift_neg = 1'b0; drift_addend = 30'h3FFF_FFFF;
    do_load(3'd0, 30'd0);
    run(101);
    check("R5 clamped addend", tod_ns, 808 + 50);
    drift_en = 1'b0;
  endtask

  task automatic t_wrap();
    drift_en = 1'b0;
    do_load(3'd7, 30'(1_000_000_000 - 20));
    run(2);
    check("R6 before wrap ns", tod_ns, 1_000_000_000 - 4);
    check("R6 before wrap sec", tod_sec, 7);
    run(1);
    check("R6 wrap ns", tod_ns, 4);
    check("R6 wrap sec modulo", tod_sec, 0);
    drift_en = 1'b1; drift_neg = 1'b0; drift_addend = 30'h2000_0000;
    do_load(3'd3, 30'(1_000_000_000 - 17));
    run(2);
    check("R6 trimmed wrap ns", tod_ns, 0);
    check("R6 trimmed wrap sec", tod_sec, 4);
    drift_en = 1'b0;
  endtask

  task automatic t_load_clear();
    drift_en = 1'b1; drift_neg = 1'b0; drift_addend = 30'h2000_0000;
    do_load(3'd5, 30'd100);
    run(1);
    check("R7 step after load", tod_ns, 108);
    do_load(3'd6, 30'd300);
    check("R7 load overrides step", tod_ns, 300);
    check("R7 load sec", tod_sec, 6);
    run(1);
    check("R7 accumulator cleared", tod_ns, 308);
    drift_en = 1'b0;
  endtask

  task automatic t_hold();
    drift_en = 1'b1; drift_neg = 1'b1; drift_addend = 30'h2000_0000;
    do_load(3'd0, 30'd2000);
    run(1);
    drift_en = 1'b0;
    run(3);
    check("R8 disabled nominal", tod_ns, 2000 + 8 + 24);
    drift_en = 1'b1;
    run(1);
    check("R8 phase held", tod_ns, 2000 + 8 + 24 + 7);
    drift_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_drift(1'b0, 30'h0123_4567, 1000);
    t_drift(1'b1, 30'h0123_4567, 1000);
    t_drift(1'b0, 30'h1555_5555, 777);
    t_clamp();
    t_wrap();
    t_load_clear();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule